// File: doc/BRIEF.md
# Memory-Side Atomic Word Unit

This block sits next to a small word store and performs atomic read-modify-write operations on single 64-bit words for remote requesters. Each request names a word address, an opcode, up to two 64-bit operands and a tag that identifies the requester's completion slot. The unit reads the word, applies the operation, writes the result back when the operation calls for it, and returns the value the word held before the operation, together with the tag. The word never leaves the unit to be cached by the requester.

Opcodes fall into two groups. The first group takes no operand: read, clear, increment and decrement. The second group takes explicit operands: exchange, OR, AND, XOR, add and compare-and-swap. Requests are taken one per cycle and run strictly in arrival order through a two-stage pipeline with a registered store read. A result is forwarded straight to the next request when that request names the word that was just written, so requests to one word never interleave. A spin latch is built by acquiring with compare-and-swap from 0 to 1 and releasing with clear.

Top module: `amo_unit`

## Requirements
- R1: While rst_ni is low and after it rises, rsp_valid_o is 0 and every word of the store reads as zero.
- R2: A request sampled with req_valid_i high at a rising edge yields exactly one response, with rsp_valid_o high two rising edges later and rsp_tag_o equal to req_tag_i. A new request is accepted on every cycle, and no response appears without a request.
- R3: Opcode 4'h0 (read) returns the word and leaves it unchanged. Opcode 4'h1 (clear) returns the word and writes zero to it.
- R4: Opcode 4'h2 (increment) and opcode 4'h3 (decrement) return the prior word and write the word plus or minus 1, modulo 2^64.
- R5: Opcode 4'h8 (exchange) returns the prior word and writes operand A.
- R6: Opcodes 4'h9 (OR), 4'hA (AND), 4'hB (XOR) and 4'hC (add, modulo 2^64) return the prior word and write the prior word combined with operand A.
- R7: Opcode 4'hD (compare-and-swap) always returns the prior word. It writes operand B only when the prior word equals operand A.
- R8: Any other opcode gives a response with rsp_err_o high and rsp_data_o zero, and leaves the store unchanged. rsp_err_o is 0 on every other response.
- R9: A request that directly follows a write to the same word sees the value that write produced.
- R10: Compare-and-swap from 0 to 1 acquires a free latch word (returns 0) and fails on a held one (returns 1). A clear releases the latch.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | Request present this cycle |
| req_op_i | input | 4 | Operation code |
| req_addr_i | input | AW | Word address |
| req_opa_i | input | 64 | Operand A (compare value for compare-and-swap) |
| req_opb_i | input | 64 | Operand B (new value for compare-and-swap) |
| req_tag_i | input | TW | Completion slot of the requester |
| rsp_valid_o | output | 1 | Response present this cycle |
| rsp_tag_o | output | TW | Completion slot the response belongs to |
| rsp_data_o | output | 64 | Prior value of the word |
| rsp_err_o | output | 1 | Unknown opcode |

## Verification
Two things can fall in the same cycle: the write-back of one request and the registered store read of the next. When both name the same word, the read returns the stale value and the forwarded result must win. The bench provokes this by keeping random addresses within four words and by issuing runs of back-to-back increments and latch operations on one word. Each response is compared with an in-order reference model in the bench, which never sees a stale value.

// File: rtl/amo_pkg.sv
package amo_pkg;
  localparam int unsigned DW = 64;

  typedef enum logic [3:0] {
    OP_READ  = 4'h0,
    OP_CLEAR = 4'h1,
    OP_INC   = 4'h2,
    OP_DEC   = 4'h3,
    OP_XCHG  = 4'h8,
    OP_OR    = 4'h9,
    OP_AND   = 4'hA,
    OP_XOR   = 4'hB,
    OP_ADD   = 4'hC,
    OP_CAS   = 4'hD
  } op_e;

  typedef struct packed {
    logic [DW-1:0] wdata;
    logic          we;
    logic          err;
  } alu_res_t;
endpackage

// File: rtl/amo_alu.sv
module amo_alu
  import amo_pkg::*;
(
  input  logic [3:0]    op_i,
  input  logic [DW-1:0] old_i,
  input  logic [DW-1:0] opa_i,
  input  logic [DW-1:0] opb_i,
  output alu_res_t      res_o
);
  always_comb begin
    res_o.wdata = old_i;
    res_o.we    = 1'b1;
    res_o.err   = 1'b0;
    case (op_i)
      OP_READ:  res_o.we    = 1'b0;
      OP_CLEAR: res_o.wdata = '0;
      OP_INC:   res_o.wdata = old_i + DW'(1);
      OP_DEC:   res_o.wdata = old_i - DW'(1);
      OP_XCHG:  res_o.wdata = opa_i;
      OP_OR:    res_o.wdata = old_i | opa_i;
      OP_AND:   res_o.wdata = old_i & opa_i;
      OP_XOR:   res_o.wdata = old_i ^ opa_i;
      OP_ADD:   res_o.wdata = old_i + opa_i;
      OP_CAS: begin
        res_o.wdata = opb_i;
        res_o.we    = (old_i == opa_i);
      end
      default: begin
        res_o.we  = 1'b0;
        res_o.err = 1'b1;
      end
    endcase
  end
endmodule

// File: rtl/amo_word_store.sv
module amo_word_store #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned WIDTH = 64,
  localparam int unsigned AW = $clog2(DEPTH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             rd_en_i,
  input  logic [AW-1:0]    rd_addr_i,
  output logic [WIDTH-1:0] rd_data_o,
  input  logic             wr_en_i,
  input  logic [AW-1:0]    wr_addr_i,
  input  logic [WIDTH-1:0] wr_data_i
);
  logic [WIDTH-1:0] mem_q [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_word
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                  mem_q[i] <= '0;
      else if (wr_en_i && wr_addr_i == AW'(i))      mem_q[i] <= wr_data_i;
    end
  end

  // registered read: old contents when read and write meet on one edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      rd_data_o <= '0;
    else if (rd_en_i) rd_data_o <= mem_q[rd_addr_i];
  end
endmodule

// File: rtl/amo_unit.sv
module amo_unit
  import amo_pkg::*;
#(
  parameter int unsigned AW = 4,
  parameter int unsigned TW = 4,
  localparam int unsigned DEPTH = 1 << AW
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_valid_i,
  input  logic [3:0]    req_op_i,
  input  logic [AW-1:0] req_addr_i,
  input  logic [DW-1:0] req_opa_i,
  input  logic [DW-1:0] req_opb_i,
  input  logic [TW-1:0] req_tag_i,
  output logic          rsp_valid_o,
  output logic [TW-1:0] rsp_tag_o,
  output logic [DW-1:0] rsp_data_o,
  output logic          rsp_err_o
);
  logic          ex_valid_q;
  logic [3:0]    ex_op_q;
  logic [AW-1:0] ex_addr_q;
  logic [DW-1:0] ex_opa_q, ex_opb_q;
  logic [TW-1:0] ex_tag_q;
  logic          fwd_sel_q;
  logic [DW-1:0] fwd_data_q;
  logic [DW-1:0] rd_data, old_val;
  alu_res_t      res;
  logic          ex_we;

  assign ex_we = ex_valid_q & res.we;

  amo_word_store #(.DEPTH(DEPTH), .WIDTH(DW)) store_i (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .rd_en_i   (req_valid_i),
    .rd_addr_i (req_addr_i),
    .rd_data_o (rd_data),
    .wr_en_i   (ex_we),
    .wr_addr_i (ex_addr_q),
    .wr_data_i (res.wdata)
  );

  assign old_val = fwd_sel_q ? fwd_data_q : rd_data;

  amo_alu alu_i (
    .op_i  (ex_op_q),
    .old_i (old_val),
    .opa_i (ex_opa_q),
    .opb_i (ex_opb_q),
    .res_o (res)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ex_valid_q <= 1'b0;
      ex_op_q    <= '0;
      ex_addr_q  <= '0;
      ex_opa_q   <= '0;
      ex_opb_q   <= '0;
      ex_tag_q   <= '0;
      fwd_sel_q  <= 1'b0;
      fwd_data_q <= '0;
    end else begin
      ex_valid_q <= req_valid_i;
      if (req_valid_i) begin
        ex_op_q    <= req_op_i;
        ex_addr_q  <= req_addr_i;
        ex_opa_q   <= req_opa_i;
        ex_opb_q   <= req_opb_i;
        ex_tag_q   <= req_tag_i;
        // store read misses the write landing on this edge
        fwd_sel_q  <= ex_we && (ex_addr_q == req_addr_i);
        fwd_data_q <= res.wdata;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o <= 1'b0;
      rsp_tag_o   <= '0;
      rsp_data_o  <= '0;
      rsp_err_o   <= 1'b0;
    end else begin
      rsp_valid_o <= ex_valid_q;
      rsp_err_o   <= ex_valid_q & res.err;
      if (ex_valid_q) begin
        rsp_tag_o  <= ex_tag_q;
        rsp_data_o <= res.err ? '0 : old_val;
      end
    end
  end
endmodule

// File: rtl/amo_unit_chk.sv
module amo_unit_chk
  import amo_pkg::*;
#(
  parameter int unsigned AW = 4,
  parameter int unsigned TW = 4
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          req_valid_i,
  input logic [3:0]    req_op_i,
  input logic [AW-1:0] req_addr_i,
  input logic [TW-1:0] req_tag_i,
  input logic          rsp_valid_o,
  input logic [TW-1:0] rsp_tag_o,
  input logic [DW-1:0] rsp_data_o,
  input logic          rsp_err_o
);
  logic [1:0] since_rst_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 since_rst_q <= '0;
    else if (since_rst_q != 2'd3) since_rst_q <= since_rst_q + 2'd1;
  end

  // R2
  rsp_follows_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> ##1 rsp_valid_o);

  // R2
  rsp_tag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |-> ##2 (rsp_tag_o == $past(req_tag_i, 2)));

  // R2
  no_spurious_rsp_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (since_rst_q >= 2'd2 && !$past(req_valid_i, 2)) |-> !rsp_valid_o);

  // R8
  err_shape_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_err_o |-> (rsp_valid_o && rsp_data_o == '0));

  // R1
  reset_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    since_rst_q == 2'd0 |-> !rsp_valid_o);

  // R9
  b2b_inc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (since_rst_q >= 2'd1 && req_valid_i && req_op_i == OP_INC &&
     $past(req_valid_i) && $past(req_op_i) == OP_INC &&
     $past(req_addr_i) == req_addr_i)
    |-> ##2 (rsp_data_o == $past(rsp_data_o) + DW'(1)));

  // R3
  read_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (since_rst_q >= 2'd1 && req_valid_i && req_op_i == OP_READ &&
     $past(req_valid_i) && $past(req_op_i) == OP_READ &&
     $past(req_addr_i) == req_addr_i)
    |-> ##2 (rsp_data_o == $past(rsp_data_o)));
endmodule

bind amo_unit amo_unit_chk #(.AW(AW), .TW(TW)) chk_i (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_valid_i (req_valid_i),
  .req_op_i    (req_op_i),
  .req_addr_i  (req_addr_i),
  .req_tag_i   (req_tag_i),
  .rsp_valid_o (rsp_valid_o),
  .rsp_tag_o   (rsp_tag_o),
  .rsp_data_o  (rsp_data_o),
  .rsp_err_o   (rsp_err_o)
);

// File: tb/amo_unit_tb_top.sv
module amo_unit_tb_top;
  import amo_pkg::*;

  localparam int CLK_PERIOD = 10;
  localparam int AW = 4;
  localparam int TW = 4;
  localparam int DEPTH = 1 << AW;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          req_valid_i = 1'b0;
  logic [3:0]    req_op_i = '0;
  logic [AW-1:0] req_addr_i = '0;
  logic [63:0]   req_opa_i = '0;
  logic [63:0]   req_opb_i = '0;
  logic [TW-1:0] req_tag_i = '0;
  logic          rsp_valid_o;
  logic [TW-1:0] rsp_tag_o;
  logic [63:0]   rsp_data_o;
  logic          rsp_err_o;

  amo_unit #(.AW(AW), .TW(TW)) dut_i (.*);

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  logic [63:0]   ref_mem [DEPTH];
  int            checks = 0, failures = 0;
  bit            done = 1'b0;
  bit            pv [2];
  logic [TW-1:0] ptag [2];
  logic [63:0]   pdata [2];
  bit            perr [2];
  string         preq [2];
  logic [TW-1:0] tag_ctr = '0;
  bit            last_v = 1'b0;
  logic [AW-1:0] last_a = '0;

  function automatic bit known_op(logic [3:0] op);
    case (op)
      OP_READ, OP_CLEAR, OP_INC, OP_DEC, OP_XCHG,
      OP_OR, OP_AND, OP_XOR, OP_ADD, OP_CAS: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic [63:0] next_val(logic [3:0] op, logic [63:0] old,
                                           logic [63:0] a, logic [63:0] b);
    case (op)
      OP_CLEAR: return 64'd0;
      OP_INC:   return old + 64'd1;
      OP_DEC:   return old - 64'd1;
      OP_XCHG:  return a;
      OP_OR:    return old | a;
      OP_AND:   return old & a;
      OP_XOR:   return old ^ a;
      OP_ADD:   return old + a;
      OP_CAS:   return (old == a) ? b : old;
      default:  return old;
    endcase
  endfunction

  function automatic string req_of(logic [3:0] op);
    case (op)
      OP_READ, OP_CLEAR:             return "R3";
      OP_INC, OP_DEC:                return "R4";
      OP_XCHG:                       return "R5";
      OP_OR, OP_AND, OP_XOR, OP_ADD: return "R6";
      OP_CAS:                        return "R7";
      default:                       return "R8";
    endcase
  endfunction

  task automatic check(string r, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", r, what, act, exp);
    end
  endtask

  task automatic step(bit v, logic [3:0] op, logic [AW-1:0] addr,
                      logic [63:0] a, logic [63:0] b, string r);
    logic [63:0] old;
    @(negedge clk_i);
    if (pv[1]) begin
      check(preq[1], "rsp_valid", 64'(rsp_valid_o), 64'd1);
      check(preq[1], "rsp_tag",   64'(rsp_tag_o),   64'(ptag[1]));
      check(preq[1], "rsp_data",  rsp_data_o,       pdata[1]);
      check(preq[1], "rsp_err",   64'(rsp_err_o),   64'(perr[1]));
    end else begin
      check("R2", "idle rsp_valid", 64'(rsp_valid_o), 64'd0);
    end
    pv[1] = pv[0]; ptag[1] = ptag[0]; pdata[1] = pdata[0];
    perr[1] = perr[0]; preq[1] = preq[0];
    pv[0] = v;
    if (v) begin
      old = ref_mem[addr];
      tag_ctr = tag_ctr + 1'b1;
      ptag[0] = tag_ctr;
      if (known_op(op)) begin
        pdata[0] = old;
        perr[0] = 1'b0;
        ref_mem[addr] = next_val(op, old, a, b);
      end else begin
        pdata[0] = 64'd0;
        perr[0] = 1'b1;
      end
      if (r != "")                       preq[0] = r;
      else if (last_v && last_a == addr) preq[0] = "R9";
      else                               preq[0] = req_of(op);
    end
    last_v = v; last_a = addr;
    req_valid_i = v;
    req_op_i    = op;
    req_addr_i  = addr;
    req_opa_i   = a;
    req_opb_i   = b;
    req_tag_i   = tag_ctr;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step(1'b0, 4'h0, '0, '0, '0, "");
  endtask

  initial begin
    repeat (50000) @(posedge clk_i);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < DEPTH; i++) ref_mem[i] = '0;
    for (int i = 0; i < 2; i++) begin pv[i] = 1'b0; preq[i] = ""; end
    repeat (3) @(negedge clk_i);
    check("R1", "rsp_valid in reset", 64'(rsp_valid_o), 64'd0);
    rst_ni = 1'b1;

    // R1: all words zero after reset
    for (int i = 0; i < DEPTH; i++) step(1'b1, OP_READ, AW'(i), '0, '0, "R1");

    // R4: wrap at both ends
    step(1'b1, OP_XCHG, 4'd5, 64'hFFFF_FFFF_FFFF_FFFF, '0, "R5");
    idle(2);
    step(1'b1, OP_INC,  4'd5, '0, '0, "R4");
    idle(2);
    step(1'b1, OP_READ, 4'd5, '0, '0, "R4");
    step(1'b1, OP_DEC,  4'd6, '0, '0, "R4");
    idle(2);
    step(1'b1, OP_READ, 4'd6, '0, '0, "R4");

    // R8: unknown opcode leaves the word alone
    step(1'b1, OP_XCHG, 4'd7, 64'h1234_5678_9ABC_DEF0, '0, "R5");
    step(1'b1, 4'h5,    4'd7, 64'hDEAD, 64'hBEEF, "R8");
    step(1'b1, 4'hF,    4'd7, 64'hDEAD, 64'hBEEF, "R8");
    step(1'b1, OP_READ, 4'd7, '0, '0, "R8");

    // R10: spin latch on word 9
    step(1'b1, OP_CAS,   4'd9, 64'd0, 64'd1, "R10");
    step(1'b1, OP_CAS,   4'd9, 64'd0, 64'd1, "R10");
    step(1'b1, OP_CLEAR, 4'd9, '0, '0, "R10");
    step(1'b1, OP_CAS,   4'd9, 64'd0, 64'd1, "R10");
    step(1'b1, OP_READ,  4'd9, '0, '0, "R10");

    // R9: back-to-back increments on one word
    for (int i = 0; i < 6; i++) step(1'b1, OP_INC, 4'd3, '0, '0, "R9");
    step(1'b1, OP_ADD,  4'd3, 64'd100, '0, "R9");
    step(1'b1, OP_XOR,  4'd3, 64'hFF,  '0, "R9");
    step(1'b1, OP_READ, 4'd3, '0, '0, "R9");

    // random mix over a few words to provoke same-word collisions
    for (int n = 0; n < 3000; n++) begin
      logic [3:0]    op;
      logic [AW-1:0] ad;
      logic [63:0]   a, b;
      int            pick;
      pick = $urandom_range(0, 11);
      case (pick)
        0: op = OP_READ;  1: op = OP_CLEAR; 2: op = OP_INC;  3: op = OP_DEC;
        4: op = OP_XCHG;  5: op = OP_OR;    6: op = OP_AND;  7: op = OP_XOR;
        8: op = OP_ADD;   9, 10: op = OP_CAS;
        default: op = 4'(($urandom_range(0, 5) * 2 + 4) | 1) ^ 4'h1 ^ 4'h1;
      endcase
      if (pick == 11) op = ($urandom_range(0, 1) == 0) ? 4'h4 : 4'hE;
      ad = AW'($urandom_range(0, 3));
      a  = {$urandom(), $urandom()};
      b  = {$urandom(), $urandom()};
      if ($urandom_range(0, 7) == 0) a = 64'hFFFF_FFFF_FFFF_FFFF;
      if (op == OP_CAS && $urandom_range(0, 1) == 1) a = ref_mem[ad];
      step($urandom_range(0, 9) != 0, op, ad, a, b, "");
    end

    // final readout of the touched words
    for (int i = 0; i < 4; i++) step(1'b1, OP_READ, AW'(i), '0, '0, "R9");
    idle(3);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule